// File: doc/BRIEF.md
# Dual Edge-Capturing Input Port with Interrupt Latches

This block serves two small input groups on a host-controlled register interface. The first group is a general-purpose port of `LINES` lines. Each line can be set as an input or an output. A data write changes only the output-mode lines. The second group is an isolated input port of the same width. A strap input selects whether its reported bits follow the input level or its inverse.

Every input line passes through a two-flop synchronizer. An edge is any change between two successive synchronized samples. Per-bit rising and falling enables decide which edges count. A counted edge sets that bit's edge-status flag and the port's interrupt latch. Each port has its own write-one clear pulse, which drops that port's latch and all of its edge-status flags. An edge that is recorded in the same cycle as the clear survives the clear.

The host side is plain register strobes and combinational read views. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure: a strobe takes effect on the clock edge where it is high. On the isolated port, edges are judged on the synchronized raw input level. The polarity strap does not change which edges are seen.

Top module: `edge_io_port`

## Requirements
- R1: After reset, the direction register is all inputs (`gp_pin_oe` = 0), the output register is 0, all edge-status flags are 0, and `irq_gp` and `irq_iso` are 0.
- R2: A cycle with `wr_dir_en` high loads `wr_dir_data` into the direction register, which drives `gp_pin_oe` from the next cycle (bit = 1 means output).
- R3: A cycle with `wr_data_en` high updates only the output-register bits whose direction is output at that edge. Input-mode bits keep their previous value, and that value shows on `gp_pin_out` if the bit is later turned to output.
- R4: `rd_gp_data[LINES-1:0]` returns the output-register bit for output-mode lines and the synchronized pin level for input-mode lines. `rd_gp_data[2*LINES-1:LINES]` returns the general-purpose edge-status flags.
- R5: A 0-to-1 change in a synchronized sample sets that bit's status flag only if its rise enable is 1. A 1-to-0 change sets it only if its fall enable is 1.
- R6: A counted edge on the general-purpose port sets `irq_gp`. `irq_gp` and the status flags stay set until a clear.
- R7: A one-cycle `clr_gp` pulse resets `irq_gp` and all general-purpose status flags, and leaves the isolated port untouched.
- R8: `rd_iso_data[LINES-1:0]` equals the synchronized isolated input XOR `iso_pol` on every bit. `rd_iso_data[2*LINES-1:LINES]` returns the isolated edge-status flags.
- R9: On the isolated port, edges are detected on the synchronized raw level, whatever the value of `iso_pol`. A change of `iso_pol` alone records no edge.
- R10: A counted edge present in the same cycle as a clear for its port stays recorded: its status bit and the port interrupt are set after that cycle.
- R11: `irq_iso` is set only by isolated-port edges and cleared only by `clr_iso`, independent of `irq_gp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gp_pin_in | input | LINES | Level seen on general-purpose lines |
| gp_pin_out | output | LINES | Output register value |
| gp_pin_oe | output | LINES | Per-line output enable (direction) |
| iso_pin_in | input | LINES | Raw isolated input levels |
| iso_pol | input | 1 | 1 inverts the reported isolated bits |
| gp_rise_en | input | LINES | Rising edges count, general-purpose port |
| gp_fall_en | input | LINES | Falling edges count, general-purpose port |
| iso_rise_en | input | LINES | Rising raw edges count, isolated port |
| iso_fall_en | input | LINES | Falling raw edges count, isolated port |
| wr_dir_en | input | 1 | Direction write strobe |
| wr_dir_data | input | LINES | Direction write value |
| wr_data_en | input | 1 | Output data write strobe |
| wr_data | input | LINES | Output data write value |
| clr_gp | input | 1 | Write-one clear, general-purpose port |
| clr_iso | input | 1 | Write-one clear, isolated port |
| rd_gp_data | output | 2*LINES | {edge status, line values} |
| rd_iso_data | output | 2*LINES | {edge status, reported bits} |
| irq_gp | output | 1 | General-purpose interrupt latch |
| irq_iso | output | 1 | Isolated-port interrupt latch |

## Verification
The bench builds the block with the default of four lines. At that width it can mix output-mode and input-mode bits within one write, and it can give each line a different rise and fall enable, so counted and ignored edges both appear in one pattern. With four lines the bench can also drive a clear in the exact cycle an edge is recorded. It can flip the polarity strap while raw edges run against the reported direction.

// File: rtl/edge_io_pkg.sv
package edge_io_pkg;

  // Decide whether a change between two synchronized samples counts.
  function automatic logic edge_counts(logic prev, logic cur, logic rise_ok, logic fall_ok);
    return (!prev && cur && rise_ok) || (prev && !cur && fall_ok);
  endfunction

endpackage

// File: rtl/eio_sync.sv
module eio_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/eio_edge_track.sv
module eio_edge_track
  import edge_io_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic             clr,
  output logic [WIDTH-1:0] status,
  output logic [WIDTH-1:0] hit,
  output logic             irq
);

  logic [WIDTH-1:0] prev_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_level <= '0;
    else        prev_level <= level;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign hit[b] = edge_counts(prev_level[b], level[b], rise_en[b], fall_en[b]);

    // A new edge overrides a coincident clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[b] <= 1'b0;
      else        status[b] <= (status[b] & ~clr) | hit[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (irq & ~clr) | (|hit);
  end

endmodule

// File: rtl/edge_io_port.sv
module edge_io_port #(
  parameter int LINES = 4,
  localparam int RD_W = 2 * LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] gp_pin_in,
  output logic [LINES-1:0] gp_pin_out,
  output logic [LINES-1:0] gp_pin_oe,
  input  logic [LINES-1:0] iso_pin_in,
  input  logic             iso_pol,
  input  logic [LINES-1:0] gp_rise_en,
  input  logic [LINES-1:0] gp_fall_en,
  input  logic [LINES-1:0] iso_rise_en,
  input  logic [LINES-1:0] iso_fall_en,
  input  logic             wr_dir_en,
  input  logic [LINES-1:0] wr_dir_data,
  input  logic             wr_data_en,
  input  logic [LINES-1:0] wr_data,
  input  logic             clr_gp,
  input  logic             clr_iso,
  output logic [RD_W-1:0]  rd_gp_data,
  output logic [RD_W-1:0]  rd_iso_data,
  output logic             irq_gp,
  output logic             irq_iso
);

  logic [LINES-1:0] dir_q;
  logic [LINES-1:0] out_q;
  logic [LINES-1:0] gp_lvl;
  logic [LINES-1:0] iso_lvl;
  logic [LINES-1:0] gp_status;
  logic [LINES-1:0] iso_status;
  logic [LINES-1:0] gp_hit;
  logic [LINES-1:0] iso_hit;

  // Direction and output registers; writes respect the current direction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir_en)  dir_q <= wr_dir_data;
      if (wr_data_en) out_q <= (out_q & ~dir_q) | (wr_data & dir_q);
    end
  end

  eio_sync #(.WIDTH(LINES)) u_gp_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (gp_pin_in),
    .sync_out (gp_lvl)
  );

  eio_sync #(.WIDTH(LINES)) u_iso_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (iso_pin_in),
    .sync_out (iso_lvl)
  );

  eio_edge_track #(.WIDTH(LINES)) u_gp_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (gp_lvl),
    .rise_en (gp_rise_en),
    .fall_en (gp_fall_en),
    .clr     (clr_gp),
    .status  (gp_status),
    .hit     (gp_hit),
    .irq     (irq_gp)
  );

  // Raw level feeds the tracker; polarity only shapes the reported bits.
  eio_edge_track #(.WIDTH(LINES)) u_iso_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (iso_lvl),
    .rise_en (iso_rise_en),
    .fall_en (iso_fall_en),
    .clr     (clr_iso),
    .status  (iso_status),
    .hit     (iso_hit),
    .irq     (irq_iso)
  );

  assign gp_pin_out  = out_q;
  assign gp_pin_oe   = dir_q;
  assign rd_gp_data  = {gp_status, (out_q & dir_q) | (gp_lvl & ~dir_q)};
  assign rd_iso_data = {iso_status, iso_lvl ^ {LINES{iso_pol}}};

endmodule

// File: rtl/edge_io_chk.sv
module edge_io_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_dir_en,
  input logic [LINES-1:0] wr_dir_data,
  input logic             wr_data_en,
  input logic [LINES-1:0] wr_data,
  input logic [LINES-1:0] gp_pin_out,
  input logic [LINES-1:0] gp_pin_oe,
  input logic             clr_gp,
  input logic             clr_iso,
  input logic [LINES-1:0] gp_hit,
  input logic [LINES-1:0] iso_hit,
  input logic [LINES-1:0] gp_status,
  input logic             irq_gp,
  input logic             irq_iso
);

  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_en |=> gp_pin_oe == $past(wr_dir_data));

  p_masked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |=> gp_pin_out == (($past(gp_pin_out) & ~$past(gp_pin_oe)) |
                                  ($past(wr_data) & $past(gp_pin_oe))));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_en |=> $stable(gp_pin_out));

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_gp && !clr_gp) |=> irq_gp);

  p_status_flags_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_status != '0) |-> irq_gp);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_gp && gp_hit == '0) |=> (!irq_gp && gp_status == '0));

  p_gp_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_gp && gp_hit != '0) |=> irq_gp);

  p_iso_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_iso && iso_hit != '0) |=> irq_iso);

  p_iso_separate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_iso && !clr_iso) |=> irq_iso);

endmodule

bind edge_io_port edge_io_chk #(.LINES(LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_dir_en   (wr_dir_en),
  .wr_dir_data (wr_dir_data),
  .wr_data_en  (wr_data_en),
  .wr_data     (wr_data),
  .gp_pin_out  (gp_pin_out),
  .gp_pin_oe   (gp_pin_oe),
  .clr_gp      (clr_gp),
  .clr_iso     (clr_iso),
  .gp_hit      (gp_hit),
  .iso_hit     (iso_hit),
  .gp_status   (gp_status),
  .irq_gp      (irq_gp),
  .irq_iso     (irq_iso)
);

// File: tb/tb_edge_io_port.sv
`timescale 1ns/1ps
module tb_edge_io_port;

  localparam int LINES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES-1:0] gp_pin_in = '0, iso_pin_in = '0;
  logic iso_pol = 1'b0;
  logic [LINES-1:0] gp_rise_en = 4'b0101, gp_fall_en = 4'b0011;
  logic [LINES-1:0] iso_rise_en = 4'b1111, iso_fall_en = 4'b0000;
  logic wr_dir_en = 1'b0, wr_data_en = 1'b0, clr_gp = 1'b0, clr_iso = 1'b0;
  logic [LINES-1:0] wr_dir_data = '0, wr_data = '0;
  logic [LINES-1:0] gp_pin_out, gp_pin_oe;
  logic [2*LINES-1:0] rd_gp_data, rd_iso_data;
  logic irq_gp, irq_iso;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       req;
    int          sel;  // 0 gp read, 1 iso read, 2 {irq_iso,irq_gp}, 3 pin_out, 4 pin_oe
    logic [15:0] exp;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  edge_io_port #(.LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .gp_pin_in(gp_pin_in), .gp_pin_out(gp_pin_out),
    .gp_pin_oe(gp_pin_oe), .iso_pin_in(iso_pin_in), .iso_pol(iso_pol),
    .gp_rise_en(gp_rise_en), .gp_fall_en(gp_fall_en), .iso_rise_en(iso_rise_en),
    .iso_fall_en(iso_fall_en), .wr_dir_en(wr_dir_en), .wr_dir_data(wr_dir_data),
    .wr_data_en(wr_data_en), .wr_data(wr_data), .clr_gp(clr_gp), .clr_iso(clr_iso),
    .rd_gp_data(rd_gp_data), .rd_iso_data(rd_iso_data), .irq_gp(irq_gp), .irq_iso(irq_iso)
  );

  // Monitor: compares queued expectations shortly after a clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = exp_q.pop_front();
        case (it.sel)
          0: act = 16'(rd_gp_data);
          1: act = 16'(rd_iso_data);
          2: act = 16'({irq_iso, irq_gp});
          3: act = 16'(gp_pin_out);
          default: act = 16'(gp_pin_oe);
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_val(string req, int sel, logic [15:0] v);
    exp_q.push_back('{req, sel, v});
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic write_dir(logic [LINES-1:0] v);
    @(negedge clk); wr_dir_en = 1'b1; wr_dir_data = v;
    @(negedge clk); wr_dir_en = 1'b0;
  endtask

  task automatic write_data(logic [LINES-1:0] v);
    @(negedge clk); wr_data_en = 1'b1; wr_data = v;
    @(negedge clk); wr_data_en = 1'b0;
  endtask

  task automatic pulse_gp_clr();
    @(negedge clk); clr_gp = 1'b1;
    @(negedge clk); clr_gp = 1'b0;
  endtask

  task automatic pulse_iso_clr();
    @(negedge clk); clr_iso = 1'b1;
    @(negedge clk); clr_iso = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    expect_val("R1 gp read", 0, 16'h00);
    expect_val("R1 iso read", 1, 16'h00);
    expect_val("R1 irqs", 2, 16'h0);
    expect_val("R1 pin_out", 3, 16'h0);
    expect_val("R1 pin_oe", 4, 16'h0);

    // R2 direction load
    write_dir(4'b1100);
    expect_val("R2 oe", 4, 16'hC);

    // R3 only output bits take data; input bits keep old value
    write_data(4'b1111);
    expect_val("R3 masked write", 3, 16'hC);
    write_dir(4'b1111);
    expect_val("R3 input bits untouched", 3, 16'hC);
    write_dir(4'b1100);

    // R4 mixed read: outputs from register, inputs from pins
    settle();
    expect_val("R4 mixed read", 0, 16'h0C);

    // R5/R6 enabled rising edge on bit0
    @(negedge clk); gp_pin_in = 4'b0001;
    settle();
    expect_val("R5 R6 rise counted", 0, 16'h1D);
    expect_val("R6 irq_gp set", 2, 16'h1);

    // R5 bit1 rise not enabled, bit0 fall enabled (already set)
    @(negedge clk); gp_pin_in = 4'b0010;
    settle();
    expect_val("R5 disabled rise ignored", 0, 16'h1E);

    // R7 clear
    pulse_gp_clr();
    settle();
    expect_val("R7 status cleared", 0, 16'h0E);
    expect_val("R7 irq_gp cleared", 2, 16'h0);

    // R5 enabled fall on bit1
    @(negedge clk); gp_pin_in = 4'b0000;
    settle();
    expect_val("R5 fall counted", 0, 16'h2C);

    // R10 clear in the cycle the bit2 rise is recorded
    @(negedge clk); gp_pin_in = 4'b0100;
    @(negedge clk);
    @(negedge clk); clr_gp = 1'b1;
    @(negedge clk); clr_gp = 1'b0;
    settle();
    expect_val("R10 edge survives clear", 0, 16'h4C);
    expect_val("R10 irq kept", 2, 16'h1);

    // R8/R11 isolated port, polarity 0
    @(negedge clk); iso_pin_in = 4'b0011;
    settle();
    expect_val("R8 iso read", 1, 16'h33);
    expect_val("R11 both irqs", 2, 16'h3);
    pulse_gp_clr();
    settle();
    expect_val("R11 iso irq independent", 2, 16'h2);
    expect_val("R7 iso untouched", 1, 16'h33);

    // R9 polarity change alone records nothing
    pulse_iso_clr();
    @(negedge clk); iso_pol = 1'b1;
    settle();
    expect_val("R9 R8 inverted, no edge", 1, 16'h0C);
    expect_val("R9 no iso irq", 2, 16'h0);

    // R9 raw fall (reported rise) not enabled
    @(negedge clk); iso_pin_in = 4'b0010;
    settle();
    expect_val("R9 raw fall ignored", 1, 16'h0D);

    // R9 raw rise (reported fall) enabled
    @(negedge clk); iso_pin_in = 4'b0110;
    settle();
    expect_val("R9 raw rise counted", 1, 16'h49);
    expect_val("R9 irq_iso set", 2, 16'h2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule